// File: doc/BRIEF.md
# Ballast Start-up Phase Sequencer with Test Acceleration

This block times the start-up of a fluorescent lamp ballast. After power-up it steps through four timed phases (filament preheat, ignition timeout, pre-run and a second end-of-life window) and then stays in a run state. A 1 ms timebase tick drives every duration. Each phase end gives a one-cycle pulse so that the lamp-drive logic around the block can change its operating point.

A production test mode shortens each phase by a factor of its own. Four comparator flags arm this mode: supply above its high threshold, run-frequency pin near 5 V, preheat-frequency pin near 5 V, and the start-up hold pin above its threshold. The mode can only be armed while start-up is held off. Once armed it stays set until the block is reset, even after the pins are released.

When the hold flag drops, the sequence starts. Timing is done by adding a step of 1 in normal mode, or the phase's factor in test mode, on every tick. A phase ends as soon as the sum reaches the nominal duration, so accelerated times that are not whole ticks round up to the next tick.

Top module: `ballast_phase_seq`

## Requirements
- R1: After `rst_n` is low, `phase` is 0 (idle), `phase_done` is 0 and `test_active` is 0.
- R2: While `phase` is idle and `start_hold` is 1, `phase` stays idle whatever `tick_ms` does.
- R3: With `phase` idle, sampling `start_hold` as 0 at a clock edge moves `phase` to 1 (preheat) at that edge.
- R4: `test_active` rises at the edge after a cycle in which `phase` is idle and `start_hold`, `supply_hi`, `run_pin_5v` and `pre_pin_5v` are all 1. Any partial combination leaves it at 0.
- R5: Once set, `test_active` stays 1 until `rst_n` goes low, even if any of the arming flags change.
- R6: Flag combinations that occur outside the idle phase never set `test_active`.
- R7: Phases advance in the order preheat (1), ignition timeout (2), pre-run (3), EOL2 (4), run (5).
- R8: In normal mode, phases 1 to 4 last 2500, 237, 625 and 2500 ticks.
- R9: In test mode the tick steps are 4, 2, 15 and 60, so phases 1 to 4 last 625, 119, 42 and 42 ticks (the nominal duration divided by the step, rounded up).
- R10: `phase_done` is 1 for exactly the one cycle that follows the edge on which a timed phase ends. It is 0 at all other times.
- R11: In run (5), further ticks change neither `phase` nor `phase_done`.
- R12: Once the sequence has left idle, `start_hold` has no effect on the phase timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_ms | input | 1 | One-cycle pulse every 1 ms |
| supply_hi | input | 1 | Supply above its test-arming threshold |
| run_pin_5v | input | 1 | Run-frequency pin at about 5 V |
| pre_pin_5v | input | 1 | Preheat-frequency pin at about 5 V |
| start_hold | input | 1 | Hold pin high: keeps the block in idle |
| phase | output | 3 | Current phase, 0 idle to 5 run |
| phase_done | output | 1 | One-cycle pulse at each timed phase end |
| test_active | output | 1 | Test acceleration armed |

## Verification
The assertions take for granted that `tick_ms` never makes a phase end on two consecutive cycles. With the default durations and steps, every phase needs at least 42 ticks, so this always holds. They also take for granted that all flags are synchronous to `clk`. The stimulus drives every input on the falling edge and gives each tick as a single-cycle pulse with random gaps. It randomises the comparator flags in two places: in idle, where either partial or full arming patterns are applied, and in the middle of the phases, where full patterns and hold pulses must have no effect.

// File: rtl/bps_pkg.sv
// Shared types for the ballast phase sequencer.
package bps_pkg;
    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_PREHEAT = 3'd1,
        PH_IGNITE  = 3'd2,
        PH_PRERUN  = 3'd3,
        PH_EOL2    = 3'd4,
        PH_RUN     = 3'd5
    } phase_t;
endpackage

// File: rtl/bps_arm.sv
// Test-mode arming latch.
// Sets when all arming flags are high inside the arming window. Clears only on reset.
// Assumes all inputs are synchronous to clk.
module bps_arm (
    input  logic clk,
    input  logic rst_n,
    input  logic window,
    input  logic supply_hi,
    input  logic run_pin_5v,
    input  logic pre_pin_5v,
    output logic armed
);
    // Sticky set on a full arming pattern inside the window.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed <= 1'b0;
        else if (window && supply_hi && run_pin_5v && pre_pin_5v)
            armed <= 1'b1;
    end
endmodule

// File: rtl/bps_timer.sv
// Phase duration accumulator.
// Adds a step on each tick and flags expiry when the sum reaches the limit.
// Assumes the step is at least 1 and that limit plus step fits in CNT_W+1 bits.
module bps_timer #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             tick,
    input  logic [CNT_W-1:0] step,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);
    logic [CNT_W-1:0] acc;
    logic [CNT_W:0]   sum;

    // Next accumulated value and comparison against the phase limit.
    always_comb begin
        sum    = {1'b0, acc} + {1'b0, step};
        expire = active && tick && (sum >= {1'b0, limit});
    end

    // Accumulate on ticks; clear when idle or at a phase end.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc <= '0;
        else if (!active || expire)
            acc <= '0;
        else if (tick)
            acc <= sum[CNT_W-1:0];
    end
endmodule

// File: rtl/bps_fsm.sv
// Phase state machine.
// Leaves idle when the hold flag drops, steps through the timed phases on timer expiry, then parks in run.
// Assumes expire is only asserted while a timed phase is active.
module bps_fsm
    import bps_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   hold,
    input  logic   expire,
    output phase_t ph,
    output logic   done
);
    phase_t ph_nx;

    // Next-phase selection.
    always_comb begin
        ph_nx = ph;
        case (ph)
            PH_IDLE:    if (!hold)  ph_nx = PH_PREHEAT;
            PH_PREHEAT: if (expire) ph_nx = PH_IGNITE;
            PH_IGNITE:  if (expire) ph_nx = PH_PRERUN;
            PH_PRERUN:  if (expire) ph_nx = PH_EOL2;
            PH_EOL2:    if (expire) ph_nx = PH_RUN;
            default:    ph_nx = PH_RUN;
        endcase
    end

    // Phase register and one-cycle end pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph   <= PH_IDLE;
            done <= 1'b0;
        end else begin
            ph   <= ph_nx;
            done <= expire;
        end
    end
endmodule

// File: rtl/ballast_phase_seq.sv
// Ballast start-up phase sequencer with test-mode acceleration.
// Times preheat, ignition timeout, pre-run and EOL2 on a 1 ms tick. Each phase has its own
// acceleration step in test mode.
// Assumes tick_ms is a single-cycle pulse and all flags are synchronous to clk.
module ballast_phase_seq
    import bps_pkg::*;
#(
    parameter int T_PREHEAT = 2500,
    parameter int T_IGNITE  = 237,
    parameter int T_PRERUN  = 625,
    parameter int T_EOL2    = 2500,
    parameter int F_PREHEAT = 4,
    parameter int F_IGNITE  = 2,
    parameter int F_PRERUN  = 15,
    parameter int F_EOL2    = 60
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_ms,
    input  logic       supply_hi,
    input  logic       run_pin_5v,
    input  logic       pre_pin_5v,
    input  logic       start_hold,
    output logic [2:0] phase,
    output logic       phase_done,
    output logic       test_active
);
    localparam int MAX_T01 = (T_PREHEAT > T_IGNITE) ? T_PREHEAT : T_IGNITE;
    localparam int MAX_T23 = (T_PRERUN > T_EOL2) ? T_PRERUN : T_EOL2;
    localparam int MAX_T   = (MAX_T01 > MAX_T23) ? MAX_T01 : MAX_T23;
    localparam int MAX_F01 = (F_PREHEAT > F_IGNITE) ? F_PREHEAT : F_IGNITE;
    localparam int MAX_F23 = (F_PRERUN > F_EOL2) ? F_PRERUN : F_EOL2;
    localparam int MAX_F   = (MAX_F01 > MAX_F23) ? MAX_F01 : MAX_F23;
    localparam int CNT_W   = $clog2(MAX_T + MAX_F + 1);

    phase_t           ph;
    logic             armed;
    logic             expire;
    logic             timed;
    logic [CNT_W-1:0] lim_sel;
    logic [CNT_W-1:0] fac_sel;
    logic [CNT_W-1:0] step;

    // Duration and acceleration step for the current phase.
    always_comb begin
        timed   = 1'b1;
        lim_sel = CNT_W'(T_PREHEAT);
        fac_sel = CNT_W'(F_PREHEAT);
        case (ph)
            PH_PREHEAT: begin lim_sel = CNT_W'(T_PREHEAT); fac_sel = CNT_W'(F_PREHEAT); end
            PH_IGNITE:  begin lim_sel = CNT_W'(T_IGNITE);  fac_sel = CNT_W'(F_IGNITE);  end
            PH_PRERUN:  begin lim_sel = CNT_W'(T_PRERUN);  fac_sel = CNT_W'(F_PRERUN);  end
            PH_EOL2:    begin lim_sel = CNT_W'(T_EOL2);    fac_sel = CNT_W'(F_EOL2);    end
            default:    timed = 1'b0;
        endcase
        step = armed ? fac_sel : CNT_W'(1);
    end

    bps_arm u_arm (
        .clk        (clk),
        .rst_n      (rst_n),
        .window     ((ph == PH_IDLE) && start_hold),
        .supply_hi  (supply_hi),
        .run_pin_5v (run_pin_5v),
        .pre_pin_5v (pre_pin_5v),
        .armed      (armed)
    );

    bps_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (timed),
        .tick   (tick_ms),
        .step   (step),
        .limit  (lim_sel),
        .expire (expire)
    );

    bps_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold   (start_hold),
        .expire (expire),
        .ph     (ph),
        .done   (phase_done)
    );

    assign phase       = ph;
    assign test_active = armed;
endmodule

// File: rtl/bps_checker.sv
// Property checker for ballast_phase_seq, attached by bind.
// Assumes the default durations, which keep phase ends far apart.
module bps_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_ms,
    input logic       start_hold,
    input logic [2:0] phase,
    input logic       phase_done,
    input logic       test_active
);
    AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        phase <= 3'd5); // R7
    AST_IDLE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd0 && start_hold) |=> phase == 3'd0); // R2
    AST_TEST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        test_active |=> test_active); // R5
    AST_ARM_IN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(test_active) |-> $past(phase) == 3'd0); // R6
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        phase_done |=> !phase_done); // R10
    AST_DONE_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        phase_done |-> (phase == $past(phase) + 3'd1 && $past(tick_ms))); // R10
    AST_RUN_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        phase == 3'd5 |=> (phase == 3'd5 && !phase_done)); // R11
    AST_NO_RETURN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        phase != 3'd0 |=> phase != 3'd0); // R12
endmodule

bind ballast_phase_seq bps_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_ms     (tick_ms),
    .start_hold  (start_hold),
    .phase       (phase),
    .phase_done  (phase_done),
    .test_active (test_active)
);

// File: tb/sim_ballast_phase_seq.sv
`timescale 1ns/1ps
module sim_ballast_phase_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_ms = 1'b0;
    logic       supply_hi = 1'b0;
    logic       run_pin_5v = 1'b0;
    logic       pre_pin_5v = 1'b0;
    logic       start_hold = 1'b1;
    logic [2:0] phase;
    logic       phase_done;
    logic       test_active;
    int         checks = 0;
    int         errors = 0;
    bit         finished = 1'b0;

    always #2.5 clk = ~clk;

    ballast_phase_seq u0 (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .supply_hi(supply_hi),
        .run_pin_5v(run_pin_5v), .pre_pin_5v(pre_pin_5v), .start_hold(start_hold),
        .phase(phase), .phase_done(phase_done), .test_active(test_active)
    );

    function automatic int exp_ticks(int p, bit tm);
        int lim, fac, st;
        case (p)
            1: begin lim = 2500; fac = 4;  end
            2: begin lim = 237;  fac = 2;  end
            3: begin lim = 625;  fac = 15; end
            default: begin lim = 2500; fac = 60; end
        endcase
        st = tm ? fac : 1;
        return (lim + st - 1) / st;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; tick_ms = 1'b0; start_hold = 1'b1;
        supply_hi = 1'b0; run_pin_5v = 1'b0; pre_pin_5v = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Drive a random flag pattern that never contains all three arming flags.
    task automatic partial_flags();
        int r = int'($urandom % 7);
        supply_hi = r[0]; run_pin_5v = r[1]; pre_pin_5v = r[2];
    endtask

    // Step through phases 1..4 with random tick gaps and random mid-phase flag noise.
    task automatic run_phases(bit tm);
        for (int p = 1; p <= 4; p++) begin
            int n = 0;
            int ex = exp_ticks(p, tm);
            chk("R7 phase entry", int'(phase), p);
            while (1) begin
                int gap = int'($urandom % 3);
                for (int g = 0; g < gap; g++) begin
                    int r = int'($urandom % 16);
                    supply_hi = r[0]; run_pin_5v = r[1]; pre_pin_5v = r[2]; start_hold = r[3];
                    @(negedge clk);
                end
                tick_ms = 1'b1;
                @(negedge clk);
                tick_ms = 1'b0;
                n++;
                if (int'(phase) != p) begin
                    chk(tm ? "R9 test duration" : "R8 normal duration", n, ex);
                    chk("R10 done pulse at end", int'(phase_done), 1);
                    chk("R7 phase order", int'(phase), p + 1);
                    break;
                end
                chk("R10 no done mid-phase", int'(phase_done), 0);
                if (n > ex + 2) begin
                    chk("R8 phase overran", n, ex);
                    break;
                end
            end
        end
        @(negedge clk);
        chk("R10 done drops", int'(phase_done), 0);
        chk("R6 no arming mid-phase", int'(test_active), int'(tm));
    endtask

    task automatic check_run();
        for (int i = 0; i < 8; i++) begin
            tick_ms = 1'b1; @(negedge clk); tick_ms = 1'b0;
            chk("R11 run stays", int'(phase), 5);
            chk("R11 no done in run", int'(phase_done), 0);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        @(negedge clk);
        chk("R1 reset phase", int'(phase), 0);
        chk("R1 reset done", int'(phase_done), 0);
        chk("R1 reset test", int'(test_active), 0);

        // Held in idle with partial flag patterns and ticks.
        for (int i = 0; i < 30; i++) begin
            partial_flags();
            tick_ms = i[0];
            @(negedge clk);
            chk("R2 idle held", int'(phase), 0);
            chk("R4 partial no arm", int'(test_active), 0);
        end
        tick_ms = 1'b0;
        start_hold = 1'b0;
        @(negedge clk);
        chk("R3 start preheat", int'(phase), 1);
        chk("R12 hold ignored", int'(phase_done), 0);
        run_phases(1'b0);
        check_run();

        // Directed arming, then release of pins.
        do_reset();
        supply_hi = 1'b1; run_pin_5v = 1'b1; pre_pin_5v = 1'b1;
        @(negedge clk);
        chk("R4 armed", int'(test_active), 1);
        supply_hi = 1'b0; run_pin_5v = 1'b0; pre_pin_5v = 1'b0;
        repeat (5) @(negedge clk);
        chk("R5 sticky after release", int'(test_active), 1);
        start_hold = 1'b0;
        @(negedge clk);
        chk("R3 start preheat test", int'(phase), 1);
        run_phases(1'b1);
        check_run();
        chk("R5 sticky in run", int'(test_active), 1);
        do_reset();
        @(negedge clk);
        chk("R5 cleared by reset", int'(test_active), 0);

        // Random arming episodes.
        for (int it = 0; it < 3; it++) begin
            bit exp_tm = 1'b0;
            int k = 2 + int'($urandom % 6);
            do_reset();
            for (int c = 0; c < k; c++) begin
                int r = int'($urandom % 8);
                supply_hi = r[0]; run_pin_5v = r[1]; pre_pin_5v = r[2];
                if (r == 7) exp_tm = 1'b1;
                @(negedge clk);
                chk("R4 random arming", int'(test_active), int'(exp_tm));
            end
            supply_hi = 1'b0; run_pin_5v = 1'b0; pre_pin_5v = 1'b0;
            start_hold = 1'b0;
            @(negedge clk);
            chk("R3 random start", int'(phase), 1);
            run_phases(exp_tm);
            check_run();
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule